// File: doc/BRIEF.md
# I2C master bus-event sequencer

This block is the bus engine of an I2C master. Software asks for one bus event at a time by setting one command bit: a Start, a Repeated Start, a Stop, a one-byte receive, or a single acknowledge clock. The engine drives SCL and SDA through drive-low enables, as an open-drain bus expects. It clears the command bit by itself when the event is over. A write to the data buffer while the engine is idle sends that byte, MSB first, and then clocks a ninth bit to sample the slave's acknowledge. There is no queue. While an event is running, every new command and every buffer write is refused.

Bus timing comes from a reload divider of the system clock. Every event is built from four quarter-phase ticks, and each tick lasts `div_reload + 1` clock cycles. The FSM states are IDLE, START, RSTART, STOP, TXBIT, TXACK, RXBIT and ACKBIT.

Transitions between the states:
- IDLE goes to the state of the accepted command, or to TXBIT after an accepted buffer write.
- Each event state walks through quarter phases 0 to 3.
- TXBIT repeats for eight bits and then moves to TXACK.
- RXBIT repeats for eight bits.
- Every other state returns to IDLE after phase 3.

In IDLE the lines keep the levels they had at the end of the last event. A separate monitor is active when slave mode and the general-call enable are both set. It watches the bus for a Start followed by an all-zero address byte.

Top module: `i2c_evt_master`

## Requirements
- R1: Setting `ctl_cmd[0]` (start) sets `cmd_pend` to 5'b00001. The engine then releases both lines and pulls SDA low while SCL is released, which gives one Start condition. Finally it pulls SCL low. `busy` stays high for exactly 4*(div_reload+1) cycles, and both lines stay low afterwards.
- R2: Setting `ctl_cmd[1]` (repeated start) releases SDA, then SCL, and pulls SDA low while SCL is high. This gives one Start condition, after which SCL is pulled low. The event lasts 4*(div_reload+1) cycles and the bit clears by itself.
- R3: Setting `ctl_cmd[2]` (stop) pulls SDA low with SCL low, releases SCL, and then releases SDA while SCL is high. This gives one Stop condition. The event lasts 4*(div_reload+1) cycles and leaves both lines released.
- R4: A `buf_wr` while idle sends the byte MSB first on 8 SCL pulses and then releases SDA for a ninth pulse. `ack_stat` becomes the SDA level sampled on that ninth pulse: 0 means acknowledged, 1 means not acknowledged. `busy` stays high for 36*(div_reload+1) cycles.
- R5: Setting `ctl_cmd[3]` (receive) gives 8 SCL pulses with SDA released. The engine samples SDA while SCL is high, MSB first. After 32*(div_reload+1) busy cycles, `rx_data` holds the byte.
- R6: Setting `ctl_cmd[4]` (acknowledge) drives the latched `ctl_ackval` onto SDA for one SCL pulse. A value of 0 pulls SDA low (ACK) and a value of 1 releases it (NACK). The event lasts 4*(div_reload+1) cycles.
- R7: While `busy` is high, `ctl_wr` and `buf_wr` have no effect. `cmd_pend` does not change, and no extra bus event follows the current one.
- R8: When several command bits are written in one cycle, only the highest-priority one is accepted. The priority order is bit 0, bit 1, bit 2, bit 3, bit 4. A command accepted in the same cycle as a `buf_wr` wins, and the buffer write is dropped.
- R9: Within the bit states (TXBIT, TXACK, RXBIT, ACKBIT), `sda_oe` changes only while `scl_oe` is asserted in both the previous cycle and the current cycle.
- R10: `evt_irq` is a one-cycle pulse in the first cycle after `busy` falls, once for every finished event.
- R11: With `slave_en` high, the engine idle and the latched general-call enable set, a Start followed by an all-zero 8-bit address gives one `gc_irq` pulse. A non-zero address gives no pulse, and neither does any address while the enable is clear.
- R12: After reset, `busy`, `cmd_pend`, `scl_oe`, `sda_oe`, `evt_irq` and `gc_irq` are all 0. `cmd_pend` is always one-hot or zero, and a non-zero `cmd_pend` implies `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_reload | input | DIV_W | Quarter-phase length minus one, in clock cycles |
| ctl_wr | input | 1 | Control write strobe |
| ctl_cmd | input | 5 | Command bits: [0] start, [1] repeated start, [2] stop, [3] receive, [4] acknowledge |
| ctl_ackval | input | 1 | Acknowledge value for the acknowledge command (0 ACK, 1 NACK) |
| ctl_gcen | input | 1 | General-call enable, latched on every `ctl_wr` |
| buf_wr | input | 1 | Data buffer write strobe; starts a byte transmit |
| buf_wdata | input | BYTE_W | Byte to transmit |
| slave_en | input | 1 | Selects slave mode for the general-call monitor |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cmd_pend | output | 5 | Active command bit, cleared by hardware at the end of the event |
| busy | output | 1 | An event is in progress |
| ack_stat | output | 1 | Acknowledge sampled after the last transmitted byte |
| rx_data | output | BYTE_W | Last received byte |
| evt_irq | output | 1 | One-cycle pulse when an event finishes |
| gc_irq | output | 1 | One-cycle pulse on a general-call address |

## Verification
The assertions check the following on every cycle:
- `cmd_pend` stays one-hot and is covered by `busy`.
- Pending bits are frozen while an event runs.
- SDA moves only under a low SCL during bit states.
- The SDA edges during Start and Stop fall in an SCL-high window.
- The acknowledge value is held on SDA.
- `evt_irq` pulses exactly when `busy` falls.
- A general-call pulse only follows cycles in which it was enabled.

Only the bench scenarios can show the rest. These are the exact event lengths for several divider settings, the bit order and contents of sent and received bytes, and the acknowledge polarity seen on the wire. They also cover the command priority, the absence of any delayed event after a refused write, and which address bytes do or do not raise a general-call pulse.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int NCMD       = 5;
    localparam int CMD_START  = 0;
    localparam int CMD_RSTART = 1;
    localparam int CMD_STOP   = 2;
    localparam int CMD_RECV   = 3;
    localparam int CMD_ACK    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RSTART,
        ST_STOP,
        ST_TXBIT,
        ST_TXACK,
        ST_RXBIT,
        ST_ACKBIT
    } evt_state_t;

endpackage

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic [N:0] lower;

    assign lower[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_chain
            assign gnt[i]     = req[i] & ~lower[i];
            assign lower[i+1] = lower[i] | req[i];
        end
    endgenerate

endmodule

// File: rtl/i2c_evt_tick.sv
module i2c_evt_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/i2c_evt_gcsnoop.sv
module i2c_evt_gcsnoop #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl,
    input  logic sda,
    output logic hit
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic              scl_p, sda_p, active;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] sh_nx;

    assign sh_nx = {sh[BYTE_W-2:0], sda};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
            active <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            hit    <= 1'b0;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
            hit   <= 1'b0;
            if (!en) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (scl && scl_p && sda_p && !sda) begin
                active <= 1'b1;
                cnt    <= '0;
                sh     <= '0;
            end else if (active && scl && !scl_p) begin
                sh <= sh_nx;
                if (cnt == LAST) begin
                    active <= 1'b0;
                    hit    <= (sh_nx == '0);
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_evt_master.sv
module i2c_evt_master
    import i2c_evt_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_reload,
    input  logic              ctl_wr,
    input  logic [NCMD-1:0]   ctl_cmd,
    input  logic              ctl_ackval,
    input  logic              ctl_gcen,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              slave_en,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [NCMD-1:0]   cmd_pend,
    output logic              busy,
    output logic              ack_stat,
    output logic [BYTE_W-1:0] rx_data,
    output logic              evt_irq,
    output logic              gc_irq
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    evt_state_t        state_q, state_d;
    logic [1:0]        ph_q, ph_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [BYTE_W-1:0] sreg_q, rx_q;
    logic [NCMD-1:0]   gnt, pend_q;
    logic              ack_q, gcen_q, ack_stat_q;
    logic              hold_scl, hold_sda;
    logic              scl_c, sda_c;
    logic              tick, fin, idle, cmd_go, buf_go, irq_q;

    assign idle   = (state_q == ST_IDLE);
    assign cmd_go = idle && ctl_wr && (|gnt);
    assign buf_go = idle && buf_wr && !cmd_go;

    i2c_evt_prio #(.N(NCMD)) u_prio (
        .req (ctl_cmd & {NCMD{ctl_wr}}),
        .gnt (gnt)
    );

    i2c_evt_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!idle),
        .reload (div_reload),
        .tick   (tick)
    );

    i2c_evt_gcsnoop #(.BYTE_W(BYTE_W)) u_gc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (slave_en && gcen_q && idle),
        .scl   (scl_in),
        .sda   (sda_in),
        .hit   (gc_irq)
    );

    // next-state and phase sequencing
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        bit_d   = bit_q;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ph_d  = 2'd0;
                bit_d = '0;
                if (cmd_go) begin
                    if (gnt[CMD_START])       state_d = ST_START;
                    else if (gnt[CMD_RSTART]) state_d = ST_RSTART;
                    else if (gnt[CMD_STOP])   state_d = ST_STOP;
                    else if (gnt[CMD_RECV])   state_d = ST_RXBIT;
                    else                      state_d = ST_ACKBIT;
                end else if (buf_go) begin
                    state_d = ST_TXBIT;
                end
            end
            default: begin
                if (tick) begin
                    if (ph_q != 2'd3) begin
                        ph_d = ph_q + 2'd1;
                    end else begin
                        ph_d = 2'd0;
                        if (state_q == ST_TXBIT) begin
                            if (bit_q == LAST_BIT) state_d = ST_TXACK;
                            else                   bit_d   = bit_q + 1'b1;
                        end else if (state_q == ST_RXBIT && bit_q != LAST_BIT) begin
                            bit_d = bit_q + 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                            fin     = 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 2'd0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            bit_q   <= bit_d;
        end
    end

    // datapath: shift register, flags, pending bits, idle line hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q     <= '0;
            rx_q       <= '0;
            pend_q     <= '0;
            ack_q      <= 1'b0;
            gcen_q     <= 1'b0;
            ack_stat_q <= 1'b0;
            hold_scl   <= 1'b0;
            hold_sda   <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= fin;
            if (ctl_wr) gcen_q <= ctl_gcen;
            if (cmd_go) begin
                pend_q <= gnt;
                ack_q  <= ctl_ackval;
            end
            if (buf_go) sreg_q <= buf_wdata;
            if (tick) begin
                if (state_q == ST_TXBIT && ph_q == 2'd3)
                    sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
                if (state_q == ST_TXACK && ph_q == 2'd2)
                    ack_stat_q <= sda_in;
                if (state_q == ST_RXBIT && ph_q == 2'd2)
                    sreg_q <= {sreg_q[BYTE_W-2:0], sda_in};
            end
            if (fin) begin
                pend_q   <= '0;
                hold_scl <= scl_c;
                hold_sda <= sda_c;
                if (state_q == ST_RXBIT) rx_q <= sreg_q;
            end
        end
    end

    // line drive decode (1 = pull low)
    always_comb begin
        scl_c = hold_scl;
        sda_c = hold_sda;
        unique case (state_q)
            ST_IDLE: begin
                scl_c = hold_scl;
                sda_c = hold_sda;
            end
            ST_START: begin
                scl_c = (ph_q == 2'd3);
                sda_c = (ph_q != 2'd0);
            end
            ST_RSTART: begin
                scl_c = (ph_q == 2'd0) || (ph_q == 2'd3);
                sda_c = ph_q[1];
            end
            ST_STOP: begin
                scl_c = (ph_q == 2'd0);
                sda_c = !ph_q[1];
            end
            ST_TXBIT: begin
                scl_c = (ph_q == 2'd0) || (ph_q == 2'd3);
                sda_c = !sreg_q[BYTE_W-1];
            end
            ST_TXACK, ST_RXBIT: begin
                scl_c = (ph_q == 2'd0) || (ph_q == 2'd3);
                sda_c = 1'b0;
            end
            ST_ACKBIT: begin
                scl_c = (ph_q == 2'd0) || (ph_q == 2'd3);
                sda_c = !ack_q;
            end
        endcase
    end

    assign scl_oe   = scl_c;
    assign sda_oe   = sda_c;
    assign cmd_pend = pend_q;
    assign busy     = !idle;
    assign ack_stat = ack_stat_q;
    assign rx_data  = rx_q;
    assign evt_irq  = irq_q;

endmodule

// File: rtl/i2c_evt_master_chk.sv
module i2c_evt_master_chk
    import i2c_evt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic [NCMD-1:0] pend,
    input logic            scl_oe,
    input logic            sda_oe,
    input evt_state_t      state_q,
    input logic            ack_q,
    input logic            evt_irq,
    input logic            gc_irq,
    input logic            gcen_q,
    input logic            slave_en
);

    logic in_bit, in_bit_p;
    assign in_bit = (state_q == ST_TXBIT) || (state_q == ST_TXACK) ||
                    (state_q == ST_RXBIT) || (state_q == ST_ACKBIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_bit_p <= 1'b0;
        else        in_bit_p <= in_bit;
    end

    assert_pend_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend));

    assert_pend_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> busy);

    assert_pend_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pend));

    assert_sda_under_low_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bit && in_bit_p && (sda_oe != $past(sda_oe))) |-> (scl_oe && $past(scl_oe)));

    assert_start_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[CMD_START] && $past(pend[CMD_START]) && sda_oe && !$past(sda_oe))
        |-> (!scl_oe && !$past(scl_oe)));

    assert_stop_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[CMD_STOP] && $past(pend[CMD_STOP]) && !sda_oe && $past(sda_oe))
        |-> (!scl_oe && !$past(scl_oe)));

    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[CMD_ACK] && $past(pend[CMD_ACK])) |-> (sda_oe == !ack_q));

    assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |-> (!busy && $past(busy)));

    assert_irq_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> evt_irq);

    assert_gc_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gc_irq |-> ($past(gcen_q) && $past(slave_en) && !$past(busy)));

endmodule

bind i2c_evt_master i2c_evt_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .pend     (cmd_pend),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .state_q  (state_q),
    .ack_q    (ack_q),
    .evt_irq  (evt_irq),
    .gc_irq   (gc_irq),
    .gcen_q   (gcen_q),
    .slave_en (slave_en)
);

// File: tb/i2c_evt_master_bench.sv
module i2c_evt_master_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W  = 8;
    localparam int BYTE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  div_reload = '0;
    logic              ctl_wr = 1'b0;
    logic [4:0]        ctl_cmd = '0;
    logic              ctl_ackval = 1'b0;
    logic              ctl_gcen = 1'b0;
    logic              buf_wr = 1'b0;
    logic [BYTE_W-1:0] buf_wdata = '0;
    logic              slave_en = 1'b0;
    logic              scl_oe, sda_oe, busy, ack_stat, evt_irq, gc_irq;
    logic [4:0]        cmd_pend;
    logic [BYTE_W-1:0] rx_data;

    logic tb_scl_lo = 1'b0;
    logic tb_sda_lo = 1'b0;
    logic tb_sda_gc = 1'b0;
    wire  scl_line = ~(scl_oe | tb_scl_lo);
    wire  sda_line = ~(sda_oe | tb_sda_lo | tb_sda_gc);

    int nchk = 0, nfail = 0, cyc = 0, ncyc = 0;
    int starts = 0, stops = 0, capn = 0, irqs = 0, gcs = 0, fcnt = 0;
    logic [15:0] cap = '0;
    logic tx_mode = 1'b0, rx_mode = 1'b0, slv_ack = 1'b0, gcen_v = 1'b0, done = 1'b0;
    logic [7:0] rx_byte = '0;

    i2c_evt_master #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_i2c_evt_master (
        .clk(clk), .rst_n(rst_n), .div_reload(div_reload),
        .ctl_wr(ctl_wr), .ctl_cmd(ctl_cmd), .ctl_ackval(ctl_ackval), .ctl_gcen(ctl_gcen),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .slave_en(slave_en),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .cmd_pend(cmd_pend), .busy(busy), .ack_stat(ack_stat), .rx_data(rx_data),
        .evt_irq(evt_irq), .gc_irq(gc_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bus monitor
    always @(posedge scl_line) begin
        cap  = {cap[14:0], sda_line};
        capn = capn + 1;
    end
    always @(negedge sda_line) if (scl_line === 1'b1) starts = starts + 1;
    always @(posedge sda_line) if (scl_line === 1'b1) stops = stops + 1;

    // slave model: changes SDA just after SCL falls
    always @(negedge scl_line) begin
        if (tx_mode) begin
            fcnt = fcnt + 1;
            if (fcnt == 8)      tb_sda_lo = slv_ack;
            else if (fcnt == 9) tb_sda_lo = 1'b0;
        end else if (rx_mode) begin
            fcnt = fcnt + 1;
            if (fcnt < 8) tb_sda_lo = ~rx_byte[7-fcnt];
            else          tb_sda_lo = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (evt_irq) irqs = irqs + 1;
        if (gc_irq)  gcs  = gcs + 1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !done) begin
            nchk  = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] bits, input logic av, input logic bw, input logic [7:0] bv);
        @(negedge clk);
        ctl_wr     = 1'b1;
        ctl_cmd    = bits;
        ctl_ackval = av;
        ctl_gcen   = gcen_v;
        buf_wr     = bw;
        buf_wdata  = bv;
        @(negedge clk);
        ctl_wr  = 1'b0;
        ctl_cmd = '0;
        buf_wr  = 1'b0;
    endtask

    task automatic wait_idle();
        ncyc = 0;
        while (busy) begin
            ncyc = ncyc + 1;
            @(negedge clk);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gc_frame(input logic [7:0] b);
        tb_sda_gc = 1'b1;
        wait_clk(3);
        tb_scl_lo = 1'b1;
        wait_clk(3);
        for (int i = 7; i >= 0; i--) begin
            tb_sda_gc = ~b[i];
            wait_clk(2);
            tb_scl_lo = 1'b0;
            wait_clk(3);
            tb_scl_lo = 1'b1;
            wait_clk(2);
        end
        tb_sda_gc = 1'b1;
        wait_clk(2);
        tb_scl_lo = 1'b0;
        wait_clk(2);
        tb_sda_gc = 1'b0;
        wait_clk(4);
    endtask

    initial begin
        logic [7:0] tx_bytes [4];
        logic [7:0] rx_bytes [3];
        int d, q, evts;
        tx_bytes = '{8'hA5, 8'h00, 8'hFF, 8'h81};
        rx_bytes = '{8'h3C, 8'hC3, 8'h01};

        wait_clk(4);
        // reset state
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset pend", int'(cmd_pend), 0);
        chk("R12 reset lines", int'({scl_oe, sda_oe, evt_irq, gc_irq}), 0);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R12 idle after reset", int'({busy, scl_line, sda_line}), 3);

        // general-call monitor sweep
        slave_en = 1'b1;
        gcen_v = 1'b0;
        issue(5'b00000, 1'b0, 1'b0, 8'h00);
        gc_frame(8'h00);
        chk("R11 gcen clear ignores zero address", gcs, 0);
        gcen_v = 1'b1;
        issue(5'b00000, 1'b0, 1'b0, 8'h00);
        chk("R12 empty command stays idle", int'(busy), 0);
        gc_frame(8'h00);
        chk("R11 zero address hit", gcs, 1);
        gc_frame(8'h5A);
        chk("R11 nonzero address", gcs, 1);
        gc_frame(8'h80);
        chk("R11 msb-only address", gcs, 1);
        gc_frame(8'h01);
        chk("R11 lsb-only address", gcs, 1);
        gc_frame(8'h00);
        chk("R11 second zero address", gcs, 2);
        slave_en = 1'b0;
        gcen_v = 1'b0;

        for (int di = 0; di < 3; di++) begin
            d = (di == 2) ? 3 : di;
            q = 4 * (d + 1);
            div_reload = DIV_W'(d);
            starts = 0; stops = 0; irqs = 0; evts = 0;

            // start, with all bits set on the first pass
            issue((di == 0) ? 5'b11111 : 5'b00001, 1'b0, 1'b0, 8'h00);
            chk("R8 start wins", int'(cmd_pend), 1);
            wait_idle();
            evts++;
            chk("R1 start length", ncyc, q);
            chk("R1 start condition count", starts, 1);
            chk("R1 lines low after start", int'({scl_line, sda_line}), 0);
            chk("R1 pend cleared", int'(cmd_pend), 0);

            // byte transmit sweep
            for (int k = 0; k < 4; k++) begin
                slv_ack = k[0];
                fcnt = 0; capn = 0; tx_mode = 1'b1;
                issue(5'b00000, 1'b0, 1'b1, tx_bytes[k]);
                wait_idle();
                evts++;
                tx_mode = 1'b0;
                chk("R4 tx length", ncyc, 9 * q);
                chk("R4 tx pulses", capn, 9);
                chk("R4 tx byte msb first", int'(cap[8:1]), int'(tx_bytes[k]));
                chk("R4 ninth bit released or acked", int'(cap[0]), int'(!slv_ack));
                chk("R4 ack status", int'(ack_stat), int'(!slv_ack));
            end

            // repeated start via priority
            issue(5'b11110, 1'b0, 1'b0, 8'h00);
            chk("R8 repeated start wins", int'(cmd_pend), 2);
            wait_idle();
            evts++;
            chk("R2 repeated start length", ncyc, q);
            chk("R2 start condition count", starts, 2);
            chk("R2 pend cleared", int'(cmd_pend), 0);

            // receive and acknowledge sweep
            for (int k = 0; k < 3; k++) begin
                rx_byte = rx_bytes[k];
                fcnt = 0; tb_sda_lo = ~rx_byte[7]; rx_mode = 1'b1;
                issue(5'b11000, 1'b0, 1'b0, 8'h00);
                chk("R8 receive over ack", int'(cmd_pend), 8);
                wait_idle();
                evts++;
                rx_mode = 1'b0;
                tb_sda_lo = 1'b0;
                chk("R5 rx length", ncyc, 8 * q);
                chk("R5 rx byte", int'(rx_data), int'(rx_bytes[k]));
                capn = 0;
                issue(5'b10000, k[0], 1'b1, 8'h55);
                chk("R8 ack over buffer write", int'(cmd_pend), 16);
                wait_idle();
                evts++;
                chk("R6 ack length", ncyc, q);
                chk("R6 ack pulse count", capn, 1);
                chk("R6 ack level", int'(cap[0]), int'(k[0]));
            end

            // stop, with refused writes while busy
            issue(5'b00100, 1'b0, 1'b0, 8'h00);
            issue(5'b00001, 1'b0, 1'b1, 8'h00);
            chk("R7 pend unchanged while busy", int'(cmd_pend), 4);
            wait_idle();
            evts++;
            chk("R3 stop condition count", stops, 1);
            chk("R3 lines released", int'({scl_line, sda_line}), 3);
            wait_clk(40);
            chk("R7 no deferred event", int'(busy), 0);
            chk("R7 no extra start", starts, 2);
            chk("R10 event pulses", irqs, evts);
        end

        // stop length measured alone
        div_reload = DIV_W'(2);
        issue(5'b00001, 1'b0, 1'b0, 8'h00);
        wait_idle();
        issue(5'b00100, 1'b0, 1'b0, 8'h00);
        wait_idle();
        chk("R3 stop length", ncyc, 12);
        chk("R3 pend cleared", int'(cmd_pend), 0);

        finish_run();
    end

endmodule